// File: doc/BRIEF.md
# Dual-Partition CRU Access Selector

This block divides one battery-backed paged RAM card into two logical drives: a small boot partition of up to 256K and a larger RAM drive of up to 800K. It watches the host's serial control-bit (CRU) write strobes and the CRU address, and decides which partition later memory accesses go to. Its partition flag enables one of two chip-select group decoders in the paged-SRAM array and drives the top address bit of a 32K firmware RAM, of which 16K is used. Each partition therefore runs its own copy of the card firmware.

The card answers at two CRU base addresses. One is chosen by a 3-bit slot input, the other by a strap that picks between two fixed slots. In shared mode the two drives sit behind the same address, and the block infers the partition from the bit group the host wrote last. A host that moves 8 or fewer bits only ever touches the low group and reaches the boot drive. A host that moves 16 bits ends in the high group and reaches the RAM drive. In separate mode the partition follows which of the two bases matched. The bit latches and the SRAM arrays sit outside this block.

Top module: `dps_sel`

## Requirements
- R1: While rst_n is low, and after reset until the first qualified write, the partition is the RAM drive: part_boot=0, pri_grp_en=1, sec_grp_en=0, fw_a14=0. Asserting rst_n clears the state at once, without waiting for a clock edge.
- R2: card_hit is high exactly when cru_addr[15:11]=5'b00010 and cru_addr[10:8] equals either ram_slot or the boot slot (4 when boot_hi=0, 6 when boot_hi=1). cru_addr[7:5] and cru_addr[0] are ignored.
- R3: bank_wr[0] is high when cru_wr and card_hit are high and cru_addr[4]=0. bank_wr[1] is high when cru_wr and card_hit are high and cru_addr[4]=1. Otherwise both are 0. bit_sel equals cru_addr[3:1].
- R4: In shared mode (sep_mode=0), a qualified write (cru_wr and card_hit) with cru_addr[4]=0 makes part_boot=1 from the next clock edge.
- R5: In shared mode, a qualified write with cru_addr[4]=1 makes part_boot=0 from the next clock edge.
- R6: In separate mode (sep_mode=1), a qualified write that matches only the boot slot sets part_boot=1. One that matches only ram_slot sets part_boot=0. The bit group plays no part.
- R7: In separate mode, a qualified write that matches both slots leaves part_boot unchanged.
- R8: part_boot does not change on a cycle without a qualified write, that is, when cru_wr is low or card_hit is low.
- R9: pri_grp_en is the inverse of part_boot. sec_grp_en and fw_a14 both equal part_boot.
- R10: In shared mode, a burst of writes to bits 0 through 15 at one base leaves the RAM drive selected. A burst to bits 0 through 7 leaves the boot drive selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cru_addr | input | 16 | CRU byte address of the current bit transfer |
| cru_wr | input | 1 | CRU output strobe, one cycle per bit |
| sep_mode | input | 1 | 1 selects separate-address mode, 0 selects shared mode |
| ram_slot | input | 3 | Slot of the configurable base (>1000 + slot*>100) |
| boot_hi | input | 1 | Boot base strap: 0 selects >1400, 1 selects >1600 |
| card_hit | output | 1 | Address falls on either card base |
| bank_wr | output | 2 | Write enable of the low and high 8-bit latch bank |
| bit_sel | output | 3 | Bit index within the addressed bank |
| part_boot | output | 1 | Partition flag: 1 is the boot drive, 0 is the RAM drive |
| pri_grp_en | output | 1 | Enable of the primary chip-select group decoder |
| sec_grp_en | output | 1 | Enable of the secondary chip-select group decoder |
| fw_a14 | output | 1 | Top address bit of the firmware RAM |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the slot field at bits 10:8, and boot slots 4 and 6. With these values the configurable slot can be moved over every position, including the two slots that coincide with the boot base. This reaches the both-match case in separate mode, the alias bits 7:5, and an address just outside the card region. Full 8-bit and 16-bit write bursts and a reset taken while the boot drive is selected are driven as directed sequences.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic {
    PART_RAM  = 1'b0,
    PART_BOOT = 1'b1
  } part_e;

  typedef struct packed {
    logic hit_boot;
    logic hit_ram;
  } base_hit_t;
endpackage

// File: rtl/dps_rst_sync.sv
module dps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dps_base_dec.sv
module dps_base_dec
  import dps_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          SLOT_LSB  = 8,
  parameter int          SLOT_W    = 3,
  parameter logic [4:0]  REGION    = 5'b00010,
  parameter logic [2:0]  BOOT_LO   = 3'd4,
  parameter logic [2:0]  BOOT_HI   = 3'd6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SLOT_W-1:0] ram_slot,
  input  logic              boot_hi,
  output base_hit_t         hits
);
  localparam int REG_LSB = SLOT_LSB + SLOT_W;
  localparam int NUM_BASES = 2;

  logic                    region_ok;
  logic [SLOT_W-1:0]       slot_tgt [NUM_BASES];
  logic [NUM_BASES-1:0]    slot_eq;

  assign region_ok   = (addr[ADDR_W-1:REG_LSB] == REGION);
  assign slot_tgt[0] = ram_slot;
  assign slot_tgt[1] = boot_hi ? BOOT_HI[SLOT_W-1:0] : BOOT_LO[SLOT_W-1:0];

  for (genvar k = 0; k < NUM_BASES; k++) begin : g_cmp
    assign slot_eq[k] = region_ok && (addr[REG_LSB-1:SLOT_LSB] == slot_tgt[k]);
  end

  always_comb begin
    hits.hit_ram  = slot_eq[0];
    hits.hit_boot = slot_eq[1];
  end
endmodule

// File: rtl/dps_grp_dec.sv
module dps_grp_dec #(
  parameter int ADDR_W  = 16,
  parameter int GRP_LSB = 4,
  parameter int BIT_LSB = 1
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wr_q,
  output logic [1:0]                 bank_wr,
  output logic [GRP_LSB-BIT_LSB-1:0] bit_sel,
  output logic                       grp_hi
);
  localparam int NUM_BANKS = 2;

  assign grp_hi  = addr[GRP_LSB];
  assign bit_sel = addr[GRP_LSB-1:BIT_LSB];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_wr[b] = wr_q && (grp_hi == b[0]);
  end
endmodule

// File: rtl/dps_part_fsm.sv
module dps_part_fsm
  import dps_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_q,
  input  logic      sep_mode,
  input  logic      grp_hi,
  input  base_hit_t hits,
  output part_e     part
);
  part_e part_q, part_d;
  logic  part_en;

  always_comb begin
    part_d  = part_q;
    part_en = 1'b0;
    if (wr_q) begin
      if (!sep_mode) begin
        part_en = 1'b1;
        part_d  = grp_hi ? PART_RAM : PART_BOOT;
      end else if (hits.hit_boot ^ hits.hit_ram) begin
        part_en = 1'b1;
        part_d  = hits.hit_boot ? PART_BOOT : PART_RAM;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       part_q <= PART_RAM;
    else if (part_en) part_q <= part_d;
  end

  assign part = part_q;
endmodule

// File: rtl/dps_sel.sv
module dps_sel
  import dps_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SLOT_LSB = 8,
  parameter int SLOT_W   = 3,
  parameter int GRP_LSB  = 4,
  parameter int BIT_LSB  = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          cru_addr,
  input  logic                       cru_wr,
  input  logic                       sep_mode,
  input  logic [SLOT_W-1:0]          ram_slot,
  input  logic                       boot_hi,
  output logic                       card_hit,
  output logic [1:0]                 bank_wr,
  output logic [GRP_LSB-BIT_LSB-1:0] bit_sel,
  output logic                       part_boot,
  output logic                       pri_grp_en,
  output logic                       sec_grp_en,
  output logic                       fw_a14
);
  logic      rst_sync_n;
  base_hit_t hits;
  logic      wr_q;
  logic      grp_hi;
  part_e     part;

  dps_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  dps_base_dec #(
    .ADDR_W(ADDR_W), .SLOT_LSB(SLOT_LSB), .SLOT_W(SLOT_W)
  ) u_base (
    .addr(cru_addr), .ram_slot(ram_slot), .boot_hi(boot_hi), .hits(hits)
  );

  assign card_hit = hits.hit_ram | hits.hit_boot;
  assign wr_q     = cru_wr & card_hit;

  dps_grp_dec #(
    .ADDR_W(ADDR_W), .GRP_LSB(GRP_LSB), .BIT_LSB(BIT_LSB)
  ) u_grp (
    .addr(cru_addr), .wr_q(wr_q), .bank_wr(bank_wr),
    .bit_sel(bit_sel), .grp_hi(grp_hi)
  );

  dps_part_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .wr_q(wr_q), .sep_mode(sep_mode),
    .grp_hi(grp_hi), .hits(hits), .part(part)
  );

  assign part_boot  = (part == PART_BOOT);
  assign pri_grp_en = (part == PART_RAM);
  assign sec_grp_en = part_boot;
  assign fw_a14     = part_boot;
endmodule

// File: rtl/dps_sel_chk.sv
module dps_sel_chk #(
  parameter int ADDR_W  = 16,
  parameter int GRP_LSB = 4
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] cru_addr,
  input logic              cru_wr,
  input logic              sep_mode,
  input logic              card_hit,
  input logic [1:0]        bank_wr,
  input logic              part_boot,
  input logic              pri_grp_en,
  input logic              sec_grp_en,
  input logic              fw_a14
);
  AST_RESET_RAM: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> !part_boot); // R1

  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(bank_wr)); // R3

  AST_BANK_QUAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bank_wr != 2'b00) |-> (cru_wr && card_hit)); // R3

  AST_SHARED_LO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cru_wr && card_hit && !sep_mode && !cru_addr[GRP_LSB]) |=> part_boot); // R4

  AST_SHARED_HI: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cru_wr && card_hit && !sep_mode && cru_addr[GRP_LSB]) |=> !part_boot); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cru_wr && card_hit) |=> $stable(part_boot)); // R8

  AST_GRP_COMPL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($countones({pri_grp_en, sec_grp_en}) == 1) && (fw_a14 == sec_grp_en)); // R9
endmodule

bind dps_sel dps_sel_chk #(.ADDR_W(ADDR_W), .GRP_LSB(GRP_LSB)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cru_addr(cru_addr), .cru_wr(cru_wr),
  .sep_mode(sep_mode), .card_hit(card_hit), .bank_wr(bank_wr),
  .part_boot(part_boot), .pri_grp_en(pri_grp_en), .sec_grp_en(sec_grp_en),
  .fw_a14(fw_a14)
);

// File: tb/dps_sel_tb_top.sv
module dps_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cru_addr;
  logic        cru_wr;
  logic        sep_mode;
  logic [2:0]  ram_slot;
  logic        boot_hi;
  logic        card_hit;
  logic [1:0]  bank_wr;
  logic [2:0]  bit_sel;
  logic        part_boot, pri_grp_en, sec_grp_en, fw_a14;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dps_sel dut_i (
    .clk(clk), .rst_n(rst_n), .cru_addr(cru_addr), .cru_wr(cru_wr),
    .sep_mode(sep_mode), .ram_slot(ram_slot), .boot_hi(boot_hi),
    .card_hit(card_hit), .bank_wr(bank_wr), .bit_sel(bit_sel),
    .part_boot(part_boot), .pri_grp_en(pri_grp_en),
    .sec_grp_en(sec_grp_en), .fw_a14(fw_a14)
  );

  typedef struct packed {
    logic        sep;
    logic [2:0]  rs;
    logic        bh;
    logic        wr;
    logic [15:0] addr;
    logic        e_hit;
    logic [1:0]  e_bank;
    logic        e_boot;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd0, 1'b0, 1'b1, 16'h1000, 1'b1, 2'b01, 1'b1}, // R4 shared low group
    '{1'b0, 3'd0, 1'b0, 1'b1, 16'h1010, 1'b1, 2'b10, 1'b0}, // R5 shared high group
    '{1'b0, 3'd0, 1'b0, 1'b1, 16'h140E, 1'b1, 2'b01, 1'b1}, // R4 via boot base
    '{1'b0, 3'd0, 1'b0, 1'b1, 16'h141E, 1'b1, 2'b10, 1'b0}, // R5 via boot base
    '{1'b0, 3'd0, 1'b0, 1'b0, 16'h1000, 1'b1, 2'b00, 1'b0}, // R8 no strobe
    '{1'b0, 3'd0, 1'b0, 1'b1, 16'h1100, 1'b0, 2'b00, 1'b0}, // R8 no hit
    '{1'b0, 3'd0, 1'b0, 1'b1, 16'h1600, 1'b0, 2'b00, 1'b0}, // R2 strap low
    '{1'b0, 3'd0, 1'b1, 1'b1, 16'h1600, 1'b1, 2'b01, 1'b1}, // R2 strap high
    '{1'b1, 3'd0, 1'b0, 1'b1, 16'h1000, 1'b1, 2'b01, 1'b0}, // R6 ram base
    '{1'b1, 3'd0, 1'b0, 1'b1, 16'h1410, 1'b1, 2'b10, 1'b1}, // R6 boot base
    '{1'b1, 3'd4, 1'b0, 1'b1, 16'h1410, 1'b1, 2'b10, 1'b1}, // R7 both match
    '{1'b1, 3'd4, 1'b0, 1'b1, 16'h1000, 1'b0, 2'b00, 1'b1}, // R2 slot moved
    '{1'b1, 3'd4, 1'b1, 1'b1, 16'h1400, 1'b1, 2'b01, 1'b0}, // R6 ram base at 4
    '{1'b1, 3'd4, 1'b1, 1'b1, 16'h1600, 1'b1, 2'b01, 1'b1}, // R6 boot base at 6
    '{1'b1, 3'd6, 1'b1, 1'b1, 16'h1610, 1'b1, 2'b10, 1'b1}, // R7 both match
    '{1'b0, 3'd4, 1'b0, 1'b1, 16'h1410, 1'b1, 2'b10, 1'b0}, // R5 shared overlap
    '{1'b0, 3'd7, 1'b0, 1'b1, 16'h1702, 1'b1, 2'b01, 1'b1}, // R4 top slot
    '{1'b0, 3'd7, 1'b0, 1'b1, 16'h17FE, 1'b1, 2'b10, 1'b0}, // R2 alias bits
    '{1'b0, 3'd7, 1'b0, 1'b1, 16'h1800, 1'b0, 2'b00, 1'b0}  // R2 outside region
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input logic exp_boot);
    check(req, "part_boot", {31'd0, part_boot}, {31'd0, exp_boot});
    check("R9", "pri_grp_en", {31'd0, pri_grp_en}, {31'd0, ~exp_boot});
    check("R9", "sec_grp_en", {31'd0, sec_grp_en}, {31'd0, exp_boot});
    check("R9", "fw_a14", {31'd0, fw_a14}, {31'd0, exp_boot});
  endtask

  task automatic write_bit(input logic [15:0] a);
    @(negedge clk);
    cru_addr = a;
    cru_wr   = 1'b1;
    #1;
    check("R3", "bit_sel", {29'd0, bit_sel}, {29'd0, a[3:1]});
    check("R3", "bank_wr", {30'd0, bank_wr}, {30'd0, a[4] ? 2'b10 : 2'b01});
    @(posedge clk);
    #1;
    cru_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    rst_n    = 1'b0;
    cru_addr = 16'h0000;
    cru_wr   = 1'b0;
    sep_mode = 1'b0;
    ram_slot = 3'd0;
    boot_hi  = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check_outs("R1", 1'b0);
    do_reset();
    @(negedge clk);
    check_outs("R1", 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sep_mode = VEC[i].sep;
      ram_slot = VEC[i].rs;
      boot_hi  = VEC[i].bh;
      cru_wr   = VEC[i].wr;
      cru_addr = VEC[i].addr;
      #1;
      check("R2", "card_hit", {31'd0, card_hit}, {31'd0, VEC[i].e_hit});
      check("R3", "bank_wr", {30'd0, bank_wr}, {30'd0, VEC[i].e_bank});
      @(posedge clk);
      #1;
      check_outs(VEC[i].sep ? "R6" : "R4", VEC[i].e_boot);
    end

    // R10: sixteen-bit transfer ends on RAM drive
    @(negedge clk);
    cru_wr = 1'b0; sep_mode = 1'b0; ram_slot = 3'd0; boot_hi = 1'b0;
    for (int b = 0; b < 16; b++) write_bit(16'h1000 + 16'(2 * b));
    check_outs("R10", 1'b0);
    // R10: eight-bit transfer ends on boot drive
    for (int b = 0; b < 8; b++) write_bit(16'h1400 + 16'(2 * b));
    check_outs("R10", 1'b1);

    // R8: long idle with boot selected keeps the state
    repeat (10) @(posedge clk);
    #1;
    check_outs("R8", 1'b1);

    // R1: asynchronous reset while the boot drive is selected
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_outs("R1", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check_outs("R1", 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule